// File: doc/BRIEF.md
# Battery Charge Integrator with Coherent Byte Readout

This block keeps a running total of signed battery-current samples. A programmable interval divider counts ticks from an external prescaler. When the selected interval elapses it raises a one-cycle sample strobe. In that cycle the signed value on the sample input is added to a 32-bit charge total, and a 24-bit count of samples goes up by one. One control byte holds all of the settings: whether counting is enabled, a self-clearing request that zeroes both totals, a self-clearing request to measure the zero-current offset, whether that offset is subtracted from each sample, and which of four interval lengths is used.

The host uses a one-byte-per-access register port, and read data comes back one cycle after the request. The charge total and the sample count are wider than one byte, so a read of the low byte of the charge total copies both live values into a shadow pair. Every other byte of either value is read from that shadow. A multi-byte read therefore always sees both values from the same instant, even while counting goes on.

A small state machine has three states. STOP means counting is off. RUN means samples are added to the totals. CAL means samples are averaged to measure the offset. The transitions are:
- STOP to RUN when enable is set and no offset measurement is pending.
- STOP to CAL when enable and the measurement request are both set.
- RUN to CAL when a measurement is requested while enabled.
- CAL to RUN when the averaging window completes or the request is withdrawn.
- RUN to STOP or CAL to STOP when enable is cleared.

Top module: `cc_counter`

## Requirements
- R1: After reset the control byte, offset byte, charge total, sample count, shadow pair and read data are all zero, the read-valid flag is low and the machine is in STOP.
- R2: In RUN each sample strobe adds the sign-extended sample to the charge total, modulo 2^32, and adds one to the sample count. Each strobe lasts one cycle.
- R3: Control bits [5:4] select the interval. The values 0, 1, 2 and 3 give T0, T1, T2 and T3 counted ticks between strobes. A tick counts only in a cycle where the tick input is high.
- R4: With enable (control bit 0) clear, no strobe occurs and both totals hold.
- R5: Writing control bit 1 as one zeroes the charge total and the sample count on the following cycle, and the bit then reads back as zero.
- R6: The register map is 0 control, 1 offset, 2 to 5 charge total bytes from low to high, and 6 to 8 sample count bytes from low to high. Each access moves one byte, and read data is valid with the valid flag on the cycle after the request. A read of address 2 returns the live low byte and copies both live totals into the shadow. Addresses 3 to 8 return shadow bytes.
- R7: With control bit 3 set, the signed 8-bit offset (address 1) is subtracted from each sample before it is added.
- R8: Control bit 2 together with enable starts an offset measurement. The next 2^CAL_LOG2 samples (8 by default) are averaged with a floor shift and are neither added nor counted. The average, clamped to the range -128 to 127, is written into the offset byte, bit 2 clears, and counting resumes.
- R9: A measurement request made while enable is clear waits. No strobe occurs, bit 2 stays set and the offset is unchanged.
- R10: Writes to addresses 2 to 8 and to unmapped addresses are ignored, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick, counted by the interval divider |
| smp_data | input | SMP_W | Signed current sample, taken when smp_strobe is high |
| smp_strobe | output | 1 | One-cycle pulse when the interval elapses |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench runs the counters and then reads the high bytes and the count without first reading the low byte. A design that read the live values, or that copied the shadow on the wrong address, would return the newer count instead of the older one. Interval spacing is measured for several selections and with a tick that is high only every other cycle. A divider that ignored the tick or decoded the selector wrongly would show the wrong gap. Offset measurement is tested with and without enable and with a sample large enough to reach the clamp. Such a design would add the measurement samples into the total, leave the request bit set, start measuring without enable, or wrap the offset instead of clamping it. Negative samples check sign extension across all four total bytes.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int ACC_W  = 32;
    localparam int CNT_W  = 24;
    localparam int ADDR_W = 4;
    localparam int OFS_W  = 8;

    // control byte fields
    localparam int CB_EN  = 0;
    localparam int CB_CLR = 1;
    localparam int CB_CAL = 2;
    localparam int CB_OFS = 3;
    localparam int CB_IVL = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_OFS  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_ACC0 = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_ACC1 = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_ACC2 = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_ACC3 = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_CNT0 = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_CNT1 = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_CNT2 = 4'd8;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_CAL  = 2'd2
    } cc_state_e;
endpackage

// File: rtl/cc_interval.sv
module cc_interval #(
    parameter int T0 = 15,
    parameter int T1 = 62,
    parameter int T2 = 125,
    parameter int T3 = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       take
);
    localparam int M01  = (T0 > T1) ? T0 : T1;
    localparam int M23  = (T2 > T3) ? T2 : T3;
    localparam int TMAX = (M01 > M23) ? M01 : M23;
    localparam int TW   = $clog2(TMAX + 1);

    logic [TW-1:0] lim;
    logic [TW-1:0] tcnt_q;

    always_comb begin
        unique case (sel)
            2'd0: lim = TW'(T0);
            2'd1: lim = TW'(T1);
            2'd2: lim = TW'(T2);
            default: lim = TW'(T3);
        endcase
    end

    // >= guards against a count left above a shortened limit
    assign take = active && tick && (tcnt_q >= lim - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (!active || restart) begin
            tcnt_q <= '0;
        end else if (tick) begin
            tcnt_q <= take ? '0 : tcnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/cc_calib.sv
module cc_calib #(
    parameter int SMP_W    = 16,
    parameter int CAL_LOG2 = 3,
    parameter int OFS_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    take,
    input  logic signed [SMP_W-1:0] smp,
    output logic                    done,
    output logic signed [OFS_W-1:0] avg
);
    localparam int SUM_W = SMP_W + CAL_LOG2;
    localparam int NCAL  = 1 << CAL_LOG2;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OFS_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = ~HI;

    logic [CAL_LOG2:0]       n_q;
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] mean;

    assign done = (n_q == (CAL_LOG2 + 1)'(NCAL));
    assign mean = sum_q >>> CAL_LOG2;

    always_comb begin
        if (mean > HI)      avg = HI[OFS_W-1:0];
        else if (mean < LO) avg = LO[OFS_W-1:0];
        else                avg = mean[OFS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q   <= '0;
            sum_q <= '0;
        end else if (!run) begin
            n_q   <= '0;
            sum_q <= '0;
        end else if (take && !done) begin
            sum_q <= sum_q + SUM_W'(smp);
            n_q   <= n_q + (CAL_LOG2 + 1)'(1);
        end
    end
endmodule

// File: rtl/cc_counter.sv
module cc_counter
    import cc_pkg::*;
#(
    parameter int SMP_W    = 16,
    parameter int T0       = 15,
    parameter int T1       = 62,
    parameter int T2       = 125,
    parameter int T3       = 250,
    parameter int CAL_LOG2 = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [SMP_W-1:0] smp_data,
    output logic                    smp_strobe,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic                    bus_rvalid
);
    cc_state_e state_q, state_d;

    logic [5:0]              ctrl_q;
    logic signed [OFS_W-1:0] ofs_q;
    logic [ACC_W-1:0]        acc_q, sh_acc_q;
    logic [CNT_W-1:0]        cnt_q, sh_cnt_q;
    logic [7:0]              rdata_q, rd_mux;
    logic                    rvalid_q;

    logic                    wr_ctrl, wr_ofs, rd_req, take;
    logic                    acc_add, cal_finish, cal_done;
    logic signed [OFS_W-1:0] cal_avg;
    logic signed [ACC_W-1:0] delta;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
    assign wr_ofs  = bus_sel && bus_wr && (bus_addr == ADR_OFS);
    assign rd_req  = bus_sel && !bus_wr;

    cc_interval #(.T0(T0), .T1(T1), .T2(T2), .T3(T3)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q != ST_STOP),
        .restart (wr_ctrl),
        .tick    (tick),
        .sel     (ctrl_q[CB_IVL+1:CB_IVL]),
        .take    (take)
    );

    cc_calib #(.SMP_W(SMP_W), .CAL_LOG2(CAL_LOG2), .OFS_W(OFS_W)) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_CAL),
        .take  (take),
        .smp   (smp_data),
        .done  (cal_done),
        .avg   (cal_avg)
    );

    assign smp_strobe = take;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_q[CB_EN]) state_d = ctrl_q[CB_CAL] ? ST_CAL : ST_RUN;
            ST_RUN: begin
                if (!ctrl_q[CB_EN])      state_d = ST_STOP;
                else if (ctrl_q[CB_CAL]) state_d = ST_CAL;
            end
            ST_CAL: begin
                if (!ctrl_q[CB_EN])                    state_d = ST_STOP;
                else if (cal_done || !ctrl_q[CB_CAL])  state_d = ST_RUN;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        acc_add    = 1'b0;
        cal_finish = 1'b0;
        unique case (state_q)
            ST_RUN:  acc_add    = take;
            ST_CAL:  cal_finish = cal_done && ctrl_q[CB_EN] && ctrl_q[CB_CAL];
            default: ;
        endcase
    end

    always_comb begin
        delta = ACC_W'(smp_data);
        if (ctrl_q[CB_OFS]) delta = delta - ACC_W'(ofs_q);
    end

    // control and offset registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ofs_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= bus_wdata[5:0];
            end else begin
                if (ctrl_q[CB_CLR]) ctrl_q[CB_CLR] <= 1'b0;
                if (cal_finish)     ctrl_q[CB_CAL] <= 1'b0;
            end
            if (wr_ofs)          ofs_q <= bus_wdata;
            else if (cal_finish) ofs_q <= cal_avg;
        end
    end

    // live totals
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (ctrl_q[CB_CLR]) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (acc_add) begin
            acc_q <= acc_q + delta;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // read mux: only the low total byte reads live state
    always_comb begin
        case (bus_addr)
            ADR_CTRL: rd_mux = {2'b00, ctrl_q};
            ADR_OFS:  rd_mux = ofs_q;
            ADR_ACC0: rd_mux = acc_q[7:0];
            ADR_ACC1: rd_mux = sh_acc_q[15:8];
            ADR_ACC2: rd_mux = sh_acc_q[23:16];
            ADR_ACC3: rd_mux = sh_acc_q[31:24];
            ADR_CNT0: rd_mux = sh_cnt_q[7:0];
            ADR_CNT1: rd_mux = sh_cnt_q[15:8];
            ADR_CNT2: rd_mux = sh_cnt_q[23:16];
            default:  rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            sh_acc_q <= '0;
            sh_cnt_q <= '0;
        end else begin
            rvalid_q <= rd_req;
            if (rd_req) rdata_q <= rd_mux;
            if (rd_req && bus_addr == ADR_ACC0) begin
                sh_acc_q <= acc_q;
                sh_cnt_q <= cnt_q;
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/cc_counter_chk.sv
module cc_counter_chk
    import cc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input cc_state_e         state,
    input logic [5:0]        ctrl,
    input logic [ACC_W-1:0]  acc,
    input logic [CNT_W-1:0]  cnt,
    input logic              strobe,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rvalid
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc == '0 && cnt == '0 && state == ST_STOP && ctrl == '0));

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && strobe && !ctrl[CB_CLR]) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !ctrl[CB_CLR]) |=> ($stable(acc) && $stable(cnt)));

    a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> !strobe);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_CTRL && bus_wdata[CB_CLR])
        |-> ##2 (acc == '0 && cnt == '0));

    a_r6_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> rvalid);

    a_r6_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !rvalid);

    a_r8_cal_no_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAL && !ctrl[CB_CLR]) |=> ($stable(acc) && $stable(cnt)));
endmodule

bind cc_counter cc_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .ctrl      (ctrl_q),
    .acc       (acc_q),
    .cnt       (cnt_q),
    .strobe    (smp_strobe),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rvalid    (bus_rvalid)
);

// File: tb/cc_counter_test.sv
module cc_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int T0 = 4, T1 = 5, T2 = 7, T3 = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic              tick_alt = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic              smp_strobe;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              bus_rvalid;

    int total = 0;
    int bad = 0;
    int n_strobe = 0;
    int cyc = 0;
    int last_cyc = 0;
    int last_gap = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    cc_counter #(.SMP_W(16), .T0(T0), .T1(T1), .T2(T2), .T3(T3), .CAL_LOG2(3)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .smp_data(smp_data),
        .smp_strobe(smp_strobe), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always begin
        @(posedge clk);
        #2;
        if (tick_alt) tick = ~tick;
        else          tick = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: strobe timing and read scoreboard
    always @(negedge clk) begin
        cyc++;
        if (smp_strobe) begin
            n_strobe++;
            last_gap = cyc - last_cyc;
            last_cyc = cyc;
        end
        if (bus_rvalid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #2;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #2;
        bus_sel = 1'b0;
    endtask

    task automatic wait_strobes(input int k);
        automatic int base = n_strobe;
        while (n_strobe < base + k) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rvalid low", int'(bus_rvalid), 0);
        chk("R1 no strobe", int'(smp_strobe), 0);
        rd(4'd0, 8'h00, "R1 ctrl");
        rd(4'd1, 8'h00, "R1 offset");
        rd(4'd2, 8'h00, "R1 acc0");
        rd(4'd5, 8'h00, "R1 acc3");
        rd(4'd6, 8'h00, "R1 cnt0");

        // R2, R3: positive samples, interval select 0
        smp_data = 16'sd5;
        wr(4'd0, 8'h01);
        wait_strobes(6);
        wr(4'd0, 8'h00);
        chk("R3 gap sel0", last_gap, T0);
        rd(4'd2, 8'h1E, "R2 acc0 6x5");
        rd(4'd3, 8'h00, "R2 acc1");
        rd(4'd6, 8'h06, "R2 cnt0");

        // R4: disabled holds
        begin
            automatic int s = n_strobe;
            repeat (30) @(posedge clk);
            chk("R4 no strobe when disabled", n_strobe, s);
        end
        rd(4'd2, 8'h1E, "R4 acc0 held");

        // R5: clear
        wr(4'd0, 8'h02);
        rd(4'd0, 8'h00, "R5 clear bit self-clears");
        rd(4'd2, 8'h00, "R5 acc0 zero");
        rd(4'd6, 8'h00, "R5 cnt0 zero");

        // R2, R3: negative samples, interval select 3
        smp_data = -16'sd7;
        wr(4'd0, 8'h31);
        wait_strobes(5);
        wr(4'd0, 8'h00);
        chk("R3 gap sel3", last_gap, T3);
        rd(4'd2, 8'hDD, "R2 acc0 neg");
        rd(4'd3, 8'hFF, "R2 acc1 neg");
        rd(4'd4, 8'hFF, "R2 acc2 neg");
        rd(4'd5, 8'hFF, "R2 acc3 neg");
        rd(4'd6, 8'h05, "R2 cnt0 neg");

        // R6: shadow holds until the low byte is read again
        wr(4'd0, 8'h11);
        wait_strobes(3);
        wr(4'd0, 8'h00);
        chk("R3 gap sel1", last_gap, T1);
        rd(4'd6, 8'h05, "R6 cnt0 from shadow");
        rd(4'd3, 8'hFF, "R6 acc1 from shadow");
        rd(4'd2, 8'hC8, "R6 acc0 live");
        rd(4'd6, 8'h08, "R6 cnt0 new shadow");

        // R3: tick gating
        wr(4'd0, 8'h02);
        tick_alt = 1'b1;
        smp_data = 16'sd3;
        wr(4'd0, 8'h21);
        wait_strobes(3);
        wr(4'd0, 8'h00);
        chk("R3 gap sel2 half ticks", last_gap, 2 * T2);
        tick_alt = 1'b0;
        rd(4'd2, 8'h09, "R3 acc0");
        rd(4'd6, 8'h03, "R3 cnt0");

        // R7: offset subtraction
        wr(4'd0, 8'h02);
        wr(4'd1, 8'hFD);
        rd(4'd1, 8'hFD, "R7 offset readback");
        smp_data = 16'sd10;
        wr(4'd0, 8'h09);
        wait_strobes(4);
        wr(4'd0, 8'h00);
        rd(4'd2, 8'h34, "R7 acc0 4x(10-(-3))");
        rd(4'd6, 8'h04, "R7 cnt0");

        // R9: calibration without enable waits
        wr(4'd0, 8'h02);
        wr(4'd0, 8'h04);
        begin
            automatic int s = n_strobe;
            repeat (40) @(posedge clk);
            chk("R9 no strobe", n_strobe, s);
        end
        rd(4'd0, 8'h04, "R9 cal bit pending");
        rd(4'd1, 8'hFD, "R9 offset unchanged");

        // R8: calibration run, 8 samples averaged, then 3 counted
        smp_data = 16'sd20;
        wr(4'd0, 8'h35);
        wait_strobes(11);
        rd(4'd0, 8'h31, "R8 cal bit cleared");
        wr(4'd0, 8'h00);
        rd(4'd1, 8'h14, "R8 offset from average");
        rd(4'd2, 8'h3C, "R8 acc0 excludes cal samples");
        rd(4'd6, 8'h03, "R8 cnt0 excludes cal samples");

        // R8: clamp
        wr(4'd0, 8'h02);
        smp_data = -16'sd1000;
        wr(4'd0, 8'h05);
        wait_strobes(9);
        wr(4'd0, 8'h00);
        rd(4'd1, 8'h80, "R8 offset clamped");
        rd(4'd2, 8'h18, "R8 acc0 after clamp");
        rd(4'd3, 8'hFC, "R8 acc1 after clamp");
        rd(4'd6, 8'h01, "R8 cnt0 after clamp");

        // R10: ignored writes and unmapped reads
        wr(4'd2, 8'hAA);
        wr(4'd7, 8'h55);
        wr(4'd9, 8'h3F);
        rd(4'd2, 8'h18, "R10 acc0 not writable");
        rd(4'd7, 8'h00, "R10 cnt1 not writable");
        rd(4'd15, 8'h00, "R10 unmapped reads zero");
        rd(4'd0, 8'h00, "R10 unmapped write ignored");

        begin
            automatic int guard = 0;
            while (exp_q.size() != 0 && guard < 20) begin
                @(posedge clk);
                guard++;
            end
        end
        repeat (2) @(posedge clk);
        chk("R6 all reads answered", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule